// File: doc/BRIEF.md
# Reset Source Capture Controller

This block merges four reset requests into a single active-low system reset and keeps a record of which internal source caused the latest reset. The requests are an external reset pin, a power-on-clear detector, a watchdog timeout request and a low-voltage detector request. The external pin and power-on-clear are active-low and clear the record asynchronously. The two internal requests are asynchronous active-high levels and pass through a two-stage synchronizer before they have any effect.

The record is an 8-bit status byte with two sticky flags: one for a watchdog-caused reset and one for a low-voltage-caused reset. The flag logic is not reset by the system reset it drives, so software can read the cause after the reset ends. A read strobe returns the byte and clears it. The system reset output stays asserted while any source is active and for a fixed stretch of 16 clocks after the last one goes away.

Top module: `rst_cap_top`

## Requirements
- R1: `rdData` is 8 bits wide. Bit 4 holds the watchdog flag, bit 0 holds the low-voltage flag, and bits 7:5 and 3:1 always read 0.
- R2: While `extRstN` is low, both flags are 0 and `rdData` reads 00h. The clear acts asynchronously, without a clock edge.
- R3: While `porRstN` is low, both flags are 0 and `rdData` reads 00h. The clear acts asynchronously.
- R4: A high `wdogReq` sets bit 4 by the third rising clock edge after the level is first sampled. Bit 0 keeps its previous value.
- R5: A high `lowVoltReq` sets bit 0 by the third rising clock edge after the level is first sampled. Bit 4 keeps its previous value.
- R6: `rdData` shows the current flags while `rdStrobe` is high. After the clock edge that samples `rdStrobe` high, both flags are 0, unless R7 applies.
- R7: If a synchronized internal request is active at the same edge as a read strobe, its flag ends at 1. The other flag, if it has no active request, is cleared.
- R8: `sysRstN` is 0 at once while `extRstN` or `porRstN` is low. It stays 0 for exactly 16 rising edges after both are high again, and is 1 after the 16th edge.
- R9: `sysRstN` goes to 0 after the second rising edge that samples an internal request high. After the request drops, `sysRstN` stays 0 through the 17th edge and is 1 after the 18th edge (2 synchronizer edges followed by a 16-edge stretch).
- R10: The flags keep their values while `sysRstN` is asserted by an internal request. Only R2, R3 and R6 clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| porRstN | input | 1 | Power-on-clear request, active low, asynchronous |
| wdogReq | input | 1 | Watchdog reset request, active high, asynchronous |
| lowVoltReq | input | 1 | Low-voltage reset request, active high, asynchronous |
| rdStrobe | input | 1 | Read strobe for the status byte, one clock |
| rdData | output | 8 | Status byte (bit 4 watchdog, bit 0 low voltage) |
| sysRstN | output | 1 | Combined system reset, active low |

## Verification
The read-clear and the setting of a flag by a synchronized internal request can fall on the same clock edge. The bench first sets the low-voltage flag. It then holds the watchdog request until it has passed the synchronizer and pulses the read strobe while the request is still active. The result passes when the byte reads 10h afterwards: the watchdog flag survives and the low-voltage flag is cleared. A later read with no active request must then return 00h.

// File: rtl/rst_cap_pkg.sv
package rst_cap_pkg;
  localparam int NUM_INT  = 2;
  localparam int IDX_WDOG = 0;
  localparam int IDX_LOWV = 1;

  typedef struct packed {
    logic setWdog;
    logic setLowV;
    logic rdClr;
  } flagCmd_t;
endpackage

// File: rtl/rst_cap_sync.sv
module rst_cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clrN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rst_cap_ctrl.sv
module rst_cap_ctrl
  import rst_cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH     = 16
) (
  input  logic               clk,
  input  logic               clrN,
  input  logic [NUM_INT-1:0] intReq,
  input  logic               rdStrobe,
  output flagCmd_t           cmd,
  output logic               sysRstN
);
  localparam int CNT_W = $clog2(STRETCH + 1);

  logic [NUM_INT-1:0] reqSync;
  logic [CNT_W-1:0]   holdCnt;
  logic               srcActive;

  for (genvar g = 0; g < NUM_INT; g++) begin : g_sync
    rst_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .clrN(clrN),
      .din (intReq[g]),
      .dout(reqSync[g])
    );
  end

  assign srcActive = |reqSync;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)             holdCnt <= CNT_W'(STRETCH);
    else if (srcActive)    holdCnt <= CNT_W'(STRETCH);
    else if (holdCnt != 0) holdCnt <= holdCnt - 1'b1;
  end

  assign sysRstN = clrN && !srcActive && (holdCnt == '0);

  always_comb begin
    cmd.setWdog = reqSync[IDX_WDOG];
    cmd.setLowV = reqSync[IDX_LOWV];
    cmd.rdClr   = rdStrobe;
  end
endmodule

// File: rtl/rst_cap_dp.sv
module rst_cap_dp
  import rst_cap_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WDOG_BIT = 4,
  parameter int LOWV_BIT = 0
) (
  input  logic              clk,
  input  logic              clrN,
  input  flagCmd_t          cmd,
  output logic [DATA_W-1:0] rdData
);
  logic wdogFlag;
  logic lowVFlag;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      wdogFlag <= 1'b0;
      lowVFlag <= 1'b0;
    end else begin
      if (cmd.setWdog)    wdogFlag <= 1'b1;
      else if (cmd.rdClr) wdogFlag <= 1'b0;
      if (cmd.setLowV)    lowVFlag <= 1'b1;
      else if (cmd.rdClr) lowVFlag <= 1'b0;
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[WDOG_BIT] = wdogFlag;
    rdData[LOWV_BIT] = lowVFlag;
  end
endmodule

// File: rtl/rst_cap_top.sv
module rst_cap_top
  import rst_cap_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int WDOG_BIT    = 4,
  parameter int LOWV_BIT    = 0,
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH     = 16
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic              porRstN,
  input  logic              wdogReq,
  input  logic              lowVoltReq,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              sysRstN
);
  logic               clrN;
  logic [NUM_INT-1:0] intReq;
  flagCmd_t           cmd;

  assign clrN = extRstN & porRstN;

  always_comb begin
    intReq           = '0;
    intReq[IDX_WDOG] = wdogReq;
    intReq[IDX_LOWV] = lowVoltReq;
  end

  rst_cap_ctrl #(.SYNC_STAGES(SYNC_STAGES), .STRETCH(STRETCH)) u_ctrl (
    .clk     (clk),
    .clrN    (clrN),
    .intReq  (intReq),
    .rdStrobe(rdStrobe),
    .cmd     (cmd),
    .sysRstN (sysRstN)
  );

  rst_cap_dp #(.DATA_W(DATA_W), .WDOG_BIT(WDOG_BIT), .LOWV_BIT(LOWV_BIT)) u_dp (
    .clk   (clk),
    .clrN  (clrN),
    .cmd   (cmd),
    .rdData(rdData)
  );
endmodule

// File: rtl/rst_cap_chk.sv
module rst_cap_chk
  import rst_cap_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WDOG_BIT = 4,
  parameter int LOWV_BIT = 0
) (
  input logic              clk,
  input logic              clrN,
  input logic              rdStrobe,
  input logic [DATA_W-1:0] rdData,
  input logic              sysRstN,
  input flagCmd_t          cmd
);
  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << WDOG_BIT) | (DATA_W'(1) << LOWV_BIT);

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!clrN)
    (rdData & ~FLAG_MASK) == '0);

  a_r8_pin_holds_reset: assert property (@(posedge clk)
    !clrN |-> !sysRstN);

  a_r4_wdog_sets: assert property (@(posedge clk) disable iff (!clrN)
    cmd.setWdog |=> rdData[WDOG_BIT]);

  a_r5_lowv_sets: assert property (@(posedge clk) disable iff (!clrN)
    cmd.setLowV |=> rdData[LOWV_BIT]);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!clrN)
    (rdStrobe && !cmd.setWdog && !cmd.setLowV) |=> (rdData == '0));

  a_r10_lowv_held: assert property (@(posedge clk) disable iff (!clrN)
    (!rdStrobe && !cmd.setLowV) |=> $stable(rdData[LOWV_BIT]));

  a_r9_internal_resets: assert property (@(posedge clk) disable iff (!clrN)
    (cmd.setWdog || cmd.setLowV) |-> !sysRstN);
endmodule

bind rst_cap_top rst_cap_chk #(.DATA_W(DATA_W), .WDOG_BIT(WDOG_BIT), .LOWV_BIT(LOWV_BIT)) u_chk (
  .clk     (clk),
  .clrN    (clrN),
  .rdStrobe(rdStrobe),
  .rdData  (rdData),
  .sysRstN (sysRstN),
  .cmd     (cmd)
);

// File: tb/sim_rst_cap_top.sv
module sim_rst_cap_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {wdogReq, lowVoltReq, doRead, expect while held, expect after drop/read}
  localparam logic [18:0] VEC [0:NVEC-1] = '{
    {1'b1, 1'b0, 1'b0, 8'h10, 8'h10},
    {1'b0, 1'b1, 1'b1, 8'h11, 8'h00},
    {1'b0, 1'b0, 1'b1, 8'h00, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'h11, 8'h11},
    {1'b0, 1'b0, 1'b0, 8'h11, 8'h11},
    {1'b0, 1'b0, 1'b1, 8'h11, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h01, 8'h01},
    {1'b1, 1'b0, 1'b1, 8'h11, 8'h00}
  };

  logic       clk = 1'b0;
  logic       extRstN = 1'b0;
  logic       porRstN = 1'b0;
  logic       wdogReq = 1'b0;
  logic       lowVoltReq = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic       sysRstN;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cap_top u0 (
    .clk(clk), .extRstN(extRstN), .porRstN(porRstN), .wdogReq(wdogReq),
    .lowVoltReq(lowVoltReq), .rdStrobe(rdStrobe), .rdData(rdData), .sysRstN(sysRstN)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readPulse();
    rdStrobe = 1'b1;
    cyc(1);
    rdStrobe = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk("R2 reset state rdData", rdData, 8'h00);
    chk("R8 reset state sysRstN", {7'b0, sysRstN}, 8'h00);
    porRstN = 1'b1;
    cyc(1);
    extRstN = 1'b1;
    cyc(15);
    chk("R8 stretch edge 15", {7'b0, sysRstN}, 8'h00);
    cyc(1);
    chk("R8 stretch edge 16", {7'b0, sysRstN}, 8'h01);

    for (int i = 0; i < NVEC; i++) begin
      wdogReq    = VEC[i][18];
      lowVoltReq = VEC[i][17];
      cyc(4);
      chk($sformatf("R4 R5 R1 vec%0d held", i), rdData, VEC[i][15:8]);
      if (VEC[i][18] || VEC[i][17])
        chk($sformatf("R9 vec%0d sysRstN", i), {7'b0, sysRstN}, 8'h00);
      wdogReq    = 1'b0;
      lowVoltReq = 1'b0;
      cyc(3);
      if (VEC[i][16]) readPulse();
      chk($sformatf("R6 R10 vec%0d after", i), rdData, VEC[i][7:0]);
    end

    cyc(20);
    chk("R9 idle before request", {7'b0, sysRstN}, 8'h01);
    wdogReq = 1'b1;
    cyc(1);
    chk("R9 one edge after request", {7'b0, sysRstN}, 8'h01);
    cyc(1);
    chk("R9 two edges after request", {7'b0, sysRstN}, 8'h00);
    cyc(3);
    wdogReq = 1'b0;
    cyc(17);
    chk("R9 stretch edge 17", {7'b0, sysRstN}, 8'h00);
    chk("R10 flag kept through reset", rdData, 8'h10);
    cyc(1);
    chk("R9 stretch edge 18", {7'b0, sysRstN}, 8'h01);

    lowVoltReq = 1'b1;
    cyc(4);
    lowVoltReq = 1'b0;
    cyc(3);
    chk("R5 both flags before collision", rdData, 8'h11);
    wdogReq = 1'b1;
    cyc(4);
    readPulse();
    chk("R7 set wins over read", rdData, 8'h10);
    wdogReq = 1'b0;
    cyc(3);
    readPulse();
    chk("R6 read after collision", rdData, 8'h00);

    lowVoltReq = 1'b1;
    cyc(4);
    lowVoltReq = 1'b0;
    cyc(3);
    #2 extRstN = 1'b0;
    #1;
    chk("R2 async clear rdData", rdData, 8'h00);
    chk("R2 async sysRstN", {7'b0, sysRstN}, 8'h00);
    cyc(2);
    extRstN = 1'b1;
    cyc(2);

    wdogReq = 1'b1;
    cyc(4);
    wdogReq = 1'b0;
    cyc(3);
    chk("R4 flag before power-on clear", rdData, 8'h10);
    #2 porRstN = 1'b0;
    #1;
    chk("R3 async clear rdData", rdData, 8'h00);
    chk("R3 async sysRstN", {7'b0, sysRstN}, 8'h00);
    cyc(2);
    porRstN = 1'b1;
    cyc(15);
    chk("R8 por stretch edge 15", {7'b0, sysRstN}, 8'h00);
    cyc(1);
    chk("R8 por stretch edge 16", {7'b0, sysRstN}, 8'h01);
    chk("R3 flags stay clear", rdData, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule